// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Switch Fabric

This block moves up to N messages per clock from N source lines to N destination lines through log2(N) stages of two-by-two exchange elements. Before every stage the line index is permuted by a perfect shuffle, which is a one-place cyclic left rotation of the index bits. Each element then steers each message to its upper or lower output using a single bit of the message's own destination tag. No central controller exists: the path is fully determined by the tag. Every stage is registered, so a set of messages injected together reaches the outputs a fixed number of cycles later. A new set can be injected on every clock.

Exactly one path exists between any source and any destination. Two messages in the same set can therefore need the same internal link even when their destinations differ. In that case the message arriving on an element's upper input keeps the link. The losing message is removed from the fabric, and the fabric raises a per-source blocked flag so that the sender can decide what to do. Each output also reports which source its message came from.

Top module: `omega_fabric`

## Requirements
- R1: Synchronous active-high reset. While `rst` is high, every `out_valid` and `blocked` bit is low one cycle later. Messages in flight when reset is taken never appear at the outputs.
- R2: A valid message that is not blocked appears on output line d, where d is its 3-bit destination tag (`in_dest[3i+2:3i]` for source i). It appears exactly 3 cycles after it is sampled, with its payload unchanged and `out_src` for that line equal to the source index i.
- R3: A new set of messages may be applied on every clock cycle. Sets applied on consecutive cycles are each delivered intact, without interference between sets.
- R4: The line index is rotated left by one bit before each stage. Stage k (k = 0 first) steers by destination bit S-1-k, the most significant bit first: 0 selects the upper output and 1 the lower. As a consequence, source 0 to destination 1 and source 4 to destination 0 contend at the first stage, and so do source 0 to 2 and source 2 to 3 at the second stage.
- R5: When two valid messages at one element select the same output, the message on the upper input is passed. The source bit of the other message is set in `blocked` in the same cycle that the message would have reached the outputs.
- R6: A source whose valid bit is low produces no output and never blocks another message, whatever its destination bits hold. An output line that receives no message holds `out_valid` low.
- R7: Every valid input is accounted for exactly once, either as one delivered output or as one set `blocked` bit.
- R8: Sets with no shared internal link are delivered with no blocking. Examples are the identity pattern, the reversal d = 7 - i, and the rotation d = (i + 1) mod 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Per-source message present |
| in_dest | input | N*S | Per-source destination tag, S bits each, source i at bits [S*i +: S] |
| in_data | input | N*DW | Per-source payload, DW bits each |
| out_valid | output | N | Per-destination message delivered |
| out_data | output | N*DW | Per-destination payload |
| out_src | output | N*S | Per-destination index of the originating source |
| blocked | output | N | Per-source flag: that source's message lost a link |

## Verification
The fabric is driven with back-to-back sets: three conflict-free permutations, all eight sources aimed at one destination (at 0 and at 7), and pairs built to collide at exactly the first, second or last stage. The permutations show that routing and payload carriage are correct. The funnel sets show that the upper input wins at every stage, since only source 0 survives. The pair sets locate the bit order of the routing, because a wrong bit order or a missing shuffle moves or removes the collision. Sets with invalid sources carrying conflicting tags, an empty set, and a reset taken mid-flight separate genuine messages from stale or disabled ones.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect shuffle of a line index: one-place cyclic left rotation over 'bits' bits.
  function automatic int unsigned shuffle_pos(input int unsigned p, input int unsigned bits);
    int unsigned mask;
    mask = (32'd1 << bits) - 32'd1;
    return ((p << 1) | (p >> (bits - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_switch.sv
// Two-by-two exchange element. Steering bit taken from message bit BSEL.
// Upper input has priority when both inputs want the same output.
module omega_switch #(
  parameter int MW   = 22,
  parameter int BSEL = 0
) (
  input  logic          up_v,
  input  logic [MW-1:0] up_m,
  input  logic          lo_v,
  input  logic [MW-1:0] lo_m,
  output logic          o0_v,
  output logic [MW-1:0] o0_m,
  output logic          o1_v,
  output logic [MW-1:0] o1_m,
  output logic          lo_drop
);
  logic up_to0, up_to1, lo_to0, lo_to1;

  always_comb begin
    up_to0  = up_v & ~up_m[BSEL];
    up_to1  = up_v &  up_m[BSEL];
    lo_to0  = lo_v & ~lo_m[BSEL];
    lo_to1  = lo_v &  lo_m[BSEL];
    o0_v    = up_to0 | lo_to0;
    o1_v    = up_to1 | lo_to1;
    o0_m    = up_to0 ? up_m : lo_m;
    o1_m    = up_to1 ? up_m : lo_m;
    lo_drop = (up_to0 & lo_to0) | (up_to1 & lo_to1);
  end
endmodule

// File: rtl/omega_stage.sv
// One registered stage: shuffle wiring, N/2 exchange elements, pipeline register.
// Message layout: {src[S], dest[S], data[DW]}.
module omega_stage #(
  parameter int N   = 8,
  parameter int S   = 3,
  parameter int DW  = 16,
  parameter int STG = 0,
  parameter int MW  = DW + 2 * S
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    in_vld,
  input  logic [N*MW-1:0] in_msg,
  input  logic [N-1:0]    in_blk,
  output logic [N-1:0]    out_vld,
  output logic [N*MW-1:0] out_msg,
  output logic [N-1:0]    out_blk
);
  localparam int BSEL   = DW + S - 1 - STG;
  localparam int SRC_LO = DW + S;
  localparam int NSW    = N / 2;

  logic          sh_v [N];
  logic [MW-1:0] sh_m [N];
  logic [N-1:0]  nx_v;
  logic [MW-1:0] nx_m [N];
  logic [NSW-1:0] drop;
  logic [S-1:0]  drop_src [NSW];
  logic [N-1:0]  blk_n;

  for (genvar p = 0; p < N; p++) begin : g_shuf
    localparam int Q = int'(omega_pkg::shuffle_pos(p, S));
    assign sh_v[Q] = in_vld[p];
    assign sh_m[Q] = in_msg[p*MW +: MW];
  end

  for (genvar j = 0; j < NSW; j++) begin : g_sw
    omega_switch #(.MW(MW), .BSEL(BSEL)) u_sw (
      .up_v    (sh_v[2*j]),
      .up_m    (sh_m[2*j]),
      .lo_v    (sh_v[2*j+1]),
      .lo_m    (sh_m[2*j+1]),
      .o0_v    (nx_v[2*j]),
      .o0_m    (nx_m[2*j]),
      .o1_v    (nx_v[2*j+1]),
      .o1_m    (nx_m[2*j+1]),
      .lo_drop (drop[j])
    );
    assign drop_src[j] = sh_m[2*j+1][SRC_LO +: S];
  end

  always_comb begin
    blk_n = in_blk;
    for (int j = 0; j < NSW; j++) begin
      if (drop[j]) blk_n[drop_src[j]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= '0;
      out_blk <= '0;
    end else begin
      out_vld <= nx_v;
      out_blk <= blk_n;
    end
  end

  // Payload register carries no reset; it is qualified by out_vld.
  always_ff @(posedge clk) begin
    for (int o = 0; o < N; o++) begin
      out_msg[o*MW +: MW] <= nx_m[o];
    end
  end
endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int N  = 8,
  parameter int DW = 16,
  localparam int S = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    in_valid,
  input  logic [N*S-1:0]  in_dest,
  input  logic [N*DW-1:0] in_data,
  output logic [N-1:0]    out_valid,
  output logic [N*DW-1:0] out_data,
  output logic [N*S-1:0]  out_src,
  output logic [N-1:0]    blocked
);
  localparam int MW = DW + 2 * S;

  logic [N-1:0]    lv_v [S+1];
  logic [N*MW-1:0] lv_m [S+1];
  logic [N-1:0]    lv_b [S+1];
  logic [N*S-1:0]  fin_dest;

  assign lv_v[0] = in_valid;
  assign lv_b[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_pack
    assign lv_m[0][i*MW +: MW] = {S'(i), in_dest[i*S +: S], in_data[i*DW +: DW]};
  end

  for (genvar k = 0; k < S; k++) begin : g_stage
    omega_stage #(.N(N), .S(S), .DW(DW), .STG(k), .MW(MW)) u_stg (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (lv_v[k]),
      .in_msg  (lv_m[k]),
      .in_blk  (lv_b[k]),
      .out_vld (lv_v[k+1]),
      .out_msg (lv_m[k+1]),
      .out_blk (lv_b[k+1])
    );
  end

  assign out_valid = lv_v[S];
  assign blocked   = lv_b[S];

  for (genvar o = 0; o < N; o++) begin : g_out
    assign out_data[o*DW +: DW] = lv_m[S][o*MW +: DW];
    assign fin_dest[o*S +: S]   = lv_m[S][o*MW + DW +: S];
    assign out_src[o*S +: S]    = lv_m[S][o*MW + DW + S +: S];
  end
endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
  parameter int N  = 8,
  parameter int DW = 16,
  localparam int S = $clog2(N)
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   in_valid,
  input logic [N*S-1:0] in_dest,
  input logic [N-1:0]   out_valid,
  input logic [N-1:0]   blocked,
  input logic [N*S-1:0] fin_dest
);
  logic [N-1:0]   dv [S];
  logic [N*S-1:0] dd [S];
  logic [N-1:0]   lone;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < S; k++) begin
        dv[k] <= '0;
        dd[k] <= '0;
      end
    end else begin
      dv[0] <= in_valid;
      dd[0] <= in_dest;
      for (int k = 1; k < S; k++) begin
        dv[k] <= dv[k-1];
        dd[k] <= dd[k-1];
      end
    end
  end

  always_comb begin
    lone = '0;
    for (int s = 0; s < N; s++) begin
      if (dv[S-1][s]) lone[dd[S-1][s*S +: S]] = 1'b1;
    end
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && blocked == '0));

  // R2: a lone message lands on its own destination line and is never blocked
  p_lone_path_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones(dv[S-1]) == 1) |-> (out_valid == lone && blocked == '0));

  // R4: each delivered message sits on the line named by its tag
  for (genvar o = 0; o < N; o++) begin : g_route
    p_route_r4: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] |-> (fin_dest[o*S +: S] == S'(o)));
  end

  // R5: only sources that sent something can be flagged
  p_blk_src_r5: assert property (@(posedge clk) disable iff (rst)
    (blocked & ~dv[S-1]) == '0);

  // R6
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (dv[S-1] == '0) |-> (out_valid == '0));

  // R7
  p_account_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones(out_valid) + $countones(blocked)) == $countones(dv[S-1]));
endmodule

bind omega_fabric omega_fabric_chk #(.N(N), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_dest   (in_dest),
  .out_valid (out_valid),
  .blocked   (blocked),
  .fin_dest  (fin_dest)
);

// File: tb/sim_omega_fabric.sv
module sim_omega_fabric;
  localparam int N  = 8;
  localparam int S  = 3;
  localparam int DW = 16;
  localparam int NV = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    in_valid = '0;
  logic [N*S-1:0]  in_dest  = '0;
  logic [N*DW-1:0] in_data  = '0;
  logic [N-1:0]    out_valid;
  logic [N*DW-1:0] out_data;
  logic [N*S-1:0]  out_src;
  logic [N-1:0]    blocked;

  int nchk = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  omega_fabric #(.N(N), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_src(out_src), .blocked(blocked)
  );

  // {valid mask, destination tags (octal digit per source, source 7 first), expected blocked}
  localparam logic [39:0] VEC [NV] = '{
    {8'hFF, 24'o76543210, 8'h00},  // 0 identity           R8
    {8'hFF, 24'o00000000, 8'hFE},  // 1 all to 0           R5
    {8'hFF, 24'o01234567, 8'h00},  // 2 reversal           R8
    {8'h11, 24'o00000001, 8'h10},  // 3 first-stage clash  R4
    {8'h48, 24'o52555555, 8'h00},  // 4 invalid decoys     R6
    {8'h03, 24'o00000033, 8'h02},  // 5 last-stage clash   R4
    {8'h05, 24'o00000302, 8'h04},  // 6 mid-stage clash    R4
    {8'h10, 24'o00000000, 8'h00},  // 7 lower input alone  R6
    {8'h00, 24'o00000000, 8'h00},  // 8 empty              R6
    {8'hFF, 24'o77777777, 8'hFE},  // 9 all to 7           R5
    {8'hFF, 24'o07654321, 8'h00}   // 10 rotate by one     R8
  };

  function automatic string vtag(input int v);
    case (v)
      0, 2, 10: return "R8";
      1, 9:     return "R5";
      3, 5, 6:  return "R4";
      default:  return "R6";
    endcase
  endfunction

  function automatic logic [DW-1:0] pay(input int v, input int s);
    return 16'hA000 | 16'(v << 4) | 16'(s);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_vec(input int v);
    in_valid = VEC[v][39:32];
    in_dest  = VEC[v][31:8];
    for (int s = 0; s < N; s++) in_data[s*DW +: DW] = pay(v, s);
  endtask

  task automatic drive_idle();
    in_valid = '0;
    in_dest  = '0;
    in_data  = '0;
  endtask

  task automatic check_vec(input int v);
    logic [N-1:0]  vm, eb, eo;
    logic [N*S-1:0] dm;
    logic [DW-1:0] ed [N];
    logic [S-1:0]  es [N];
    vm = VEC[v][39:32];
    dm = VEC[v][31:8];
    eb = VEC[v][7:0];
    eo = '0;
    for (int o = 0; o < N; o++) begin ed[o] = '0; es[o] = '0; end
    for (int s = 0; s < N; s++) begin
      if (vm[s] && !eb[s]) begin
        eo[dm[s*S +: S]] = 1'b1;
        ed[dm[s*S +: S]] = pay(v, s);
        es[dm[s*S +: S]] = S'(s);
      end
    end
    chk(blocked == eb, vtag(v), $sformatf("vec %0d blocked", v), 32'(blocked), 32'(eb));
    chk(out_valid == eo, vtag(v), $sformatf("vec %0d out_valid", v), 32'(out_valid), 32'(eo));
    chk(($countones(out_valid) + $countones(blocked)) == $countones(vm), "R7",
        $sformatf("vec %0d accounting", v),
        32'($countones(out_valid) + $countones(blocked)), 32'($countones(vm)));
    for (int o = 0; o < N; o++) begin
      if (eo[o]) begin
        // consecutive sets overlap in the pipe: later vectors exercise R3
        chk(out_data[o*DW +: DW] == ed[o], (v > 0) ? "R3" : "R2",
            $sformatf("vec %0d data line %0d", v, o), 32'(out_data[o*DW +: DW]), 32'(ed[o]));
        chk(out_src[o*S +: S] == es[o], "R2",
            $sformatf("vec %0d source line %0d", v, o), 32'(out_src[o*S +: S]), 32'(es[o]));
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive_idle();
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1", "reset out_valid", 32'(out_valid), 32'h0);
    chk(blocked == '0, "R1", "reset blocked", 32'(blocked), 32'h0);
    rst = 1'b0;

    // Table walk, one set per cycle, each checked 3 cycles after injection.
    for (int t = 0; t < NV + 3; t++) begin
      @(negedge clk);
      if (t >= 3) check_vec(t - 3);
      if (t < NV) drive_vec(t);
      else drive_idle();
    end

    // Reset taken while a full set is in flight: nothing may emerge (R1).
    @(negedge clk);
    drive_vec(0);
    @(negedge clk);
    drive_idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid == '0, "R1", $sformatf("flush out_valid +%0d", c), 32'(out_valid), 32'h0);
      chk(blocked == '0, "R1", $sformatf("flush blocked +%0d", c), 32'(blocked), 32'h0);
    end

    // Exact latency: one message, seen on cycle 3 and not on cycle 2 (R2).
    @(negedge clk);
    in_valid = 8'h20;
    in_dest  = 24'(3'd6) << 15;
    in_data  = '0;
    in_data[5*DW +: DW] = 16'h5A5A;
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    chk(out_valid == '0, "R2", "latency not early", 32'(out_valid), 32'h0);
    @(negedge clk);
    chk(out_valid == 8'h40, "R2", "latency arrival", 32'(out_valid), 32'h40);
    chk(out_data[6*DW +: DW] == 16'h5A5A, "R2", "latency payload",
        32'(out_data[6*DW +: DW]), 32'h5A5A);
    @(negedge clk);
    chk(out_valid == '0, "R2", "single-cycle pulse", 32'(out_valid), 32'h0);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule